// File: doc/BRIEF.md
# Free Page Pool Manager

This block keeps track of the fixed-size pages of a shared frame memory in a multi-port packet switch. Every page is 256 bytes: an 8-byte header and 248 bytes of payload. A frame is stored as a chain of such pages. The memory itself sits outside this block. The block holds only the indices of pages that are currently unused. Receive ports ask for a page index before they write a new piece of an incoming frame. Transmit logic hands indices back once the frame has left, and those pages can then serve new frames.

Several ports can ask in the same cycle. A round-robin arbiter picks one of them, so at most one index leaves the pool per clock. The grant and the page index are combinational from the current request vector and the pool state. The pool also counts its free pages. When the count falls to a programmable low-water level, the block raises a full flag and names a congestion action for the port logic: send pause frames, apply back pressure, or drop incoming frames. The first two depend on enables. A return into a pool that is already complete is refused and reported.

Top module: `page_pool_mgr`

## Requirements
- R1: After reset the free count equals NUM_PAGES (512 by default, 9-bit page indices). No grant is given while no port requests, and the release error output is low.
- R2: After reset, pages are handed out in ascending index order starting at 0, until every index from 0 to NUM_PAGES-1 has been given once.
- R3: In any cycle, gnt_o is zero or one-hot and only marks a port whose alloc_req_i bit is high. gnt_page_o carries the granted page index in that same cycle.
- R4: The round-robin search for the next grant begins at the port just above the last granted one and wraps around. Port 0 has first turn after reset.
- R5: While the free count is 0, no grant is given, whatever the requests.
- R6: At each clock edge the free count drops by one for a grant and rises by one for an accepted release. When both happen in the same cycle, the count stays unchanged.
- R7: Released pages are queued in return order. They are granted after every index not yet handed out since reset, first released first granted.
- R8: A release while the free count equals NUM_PAGES is refused: rel_err_o is high for exactly the next cycle, the count does not change, and the page never reappears as a grant.
- R9: full_o is high exactly when the free count is less than or equal to thresh_i. A thresh_i of 0 flags only a completely empty pool.
- R10: While full_o is high, exactly one action output is high: pause_o if pause_en_i = 1, otherwise bp_o if bp_en_i = 1, otherwise drop_o. While full_o is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | NUM_PORTS (4) | One page request bit per port |
| rel_vld_i | input | 1 | A page index is being returned this cycle |
| rel_page_i | input | PAGE_BITS (9) | Index of the returned page |
| thresh_i | input | CNT_W (10) | Low-water level for the full flag |
| pause_en_i | input | 1 | Pause-frame flow control enabled |
| bp_en_i | input | 1 | Back pressure enabled |
| gnt_o | output | NUM_PORTS (4) | One-hot grant to the chosen port |
| gnt_page_o | output | PAGE_BITS (9) | Page index given with the grant |
| free_cnt_o | output | CNT_W (10) | Number of free pages |
| full_o | output | 1 | Free count at or below thresh_i |
| pause_o | output | 1 | Congestion action: send pause frames |
| bp_o | output | 1 | Congestion action: apply back pressure |
| drop_o | output | 1 | Congestion action: drop incoming frames |
| rel_err_o | output | 1 | Pulse: previous release hit a complete pool |

## Verification
Assertions check several rules on every cycle. The grant is one-hot and goes only to a requesting port, and nothing is granted from an empty pool. The count stays within bounds and holds when a grant and a release coincide. A refused release raises the error pulse, and the action outputs agree with the full flag. The bench scenarios are needed for the properties that depend on a history. These are the ascending hand-out order after reset, the rotation of grants among competing ports, the first-in-first-out reuse of returned pages once the fresh indices are used up, and the fact that a refused page is never handed out.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

   typedef enum logic [1:0] {
      CG_NONE  = 2'd0,
      CG_PAUSE = 2'd1,
      CG_BACKP = 2'd2,
      CG_DROP  = 2'd3
   } cong_act_e;

   function automatic int cnt_width(input int pages);
      return $clog2(pages + 1);
   endfunction

endpackage

// File: rtl/ppm_rr_arb.sv
module ppm_rr_arb #(
   parameter int NUM_PORTS = 4,
   parameter bit RR_ARB    = 1'b1,
   localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic [NUM_PORTS-1:0] req_i,
   output logic [NUM_PORTS-1:0] gnt_o
);

   logic [NUM_PORTS-1:0] pick;
   logic [PIDX_W-1:0]    pick_idx;
   logic [PIDX_W-1:0]    last_q;

   generate
      if (RR_ARB) begin : g_rr
         always_comb begin
            pick     = '0;
            pick_idx = last_q;
            for (int i = 0; i < NUM_PORTS; i++) begin
               int k;
               k = (int'(last_q) + i + 1) % NUM_PORTS;
               if (pick == '0 && req_i[PIDX_W'(k)]) begin
                  pick[PIDX_W'(k)] = 1'b1;
                  pick_idx         = PIDX_W'(k);
               end
            end
         end
      end else begin : g_fixed
         always_comb begin
            pick     = '0;
            pick_idx = last_q;
            for (int i = 0; i < NUM_PORTS; i++) begin
               if (pick == '0 && req_i[i]) begin
                  pick[i]  = 1'b1;
                  pick_idx = PIDX_W'(i);
               end
            end
         end
      end
   endgenerate

   assign gnt_o = en_i ? pick : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= PIDX_W'(NUM_PORTS - 1);
      end else if (gnt_o != '0) begin
         last_q <= pick_idx;
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R3
   AST_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0); // R3
   AST_NO_GNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> gnt_o == '0); // R5

endmodule

// File: rtl/ppm_ptr_store.sv
module ppm_ptr_store #(
   parameter int NUM_PAGES = 512,
   parameter int PAGE_BITS = 9,
   localparam int CNT_W    = ppm_pkg::cnt_width(NUM_PAGES),
   localparam int AW       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pop_i,
   input  logic                 push_i,
   input  logic [PAGE_BITS-1:0] push_page_i,
   output logic [PAGE_BITS-1:0] head_o,
   output logic [CNT_W-1:0]     count_o
);

   logic [PAGE_BITS-1:0] ring_q [NUM_PAGES];
   logic [CNT_W-1:0]     fresh_q;
   logic [CNT_W-1:0]     count_q;
   logic [AW-1:0]        rd_q;
   logic [AW-1:0]        wr_q;
   logic                 fresh_left;

   assign fresh_left = fresh_q < CNT_W'(NUM_PAGES);
   assign head_o     = fresh_left ? PAGE_BITS'(fresh_q) : ring_q[rd_q];
   assign count_o    = count_q;

   function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
      return (p == AW'(NUM_PAGES - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) begin
         ring_q[wr_q] <= push_page_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q <= '0;
         count_q <= CNT_W'(NUM_PAGES);
         rd_q    <= '0;
         wr_q    <= '0;
      end else begin
         if (pop_i) begin
            if (fresh_left) begin
               fresh_q <= fresh_q + 1'b1;
            end else begin
               rd_q <= wrap_inc(rd_q);
            end
         end
         if (push_i) begin
            wr_q <= wrap_inc(wr_q);
         end
         case ({pop_i, push_i})
            2'b10:   count_q <= count_q - 1'b1;
            2'b01:   count_q <= count_q + 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(NUM_PAGES)); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && push_i) |=> count_q == $past(count_q)); // R6
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> count_q != '0); // R5

endmodule

// File: rtl/ppm_congest.sv
module ppm_congest #(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0] free_cnt_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             pause_en_i,
   input  logic             bp_en_i,
   output logic             full_o,
   output logic             pause_o,
   output logic             bp_o,
   output logic             drop_o
);
   import ppm_pkg::*;

   cong_act_e act;

   assign full_o = free_cnt_i <= thresh_i;

   always_comb begin
      if (!full_o) begin
         act = CG_NONE;
      end else if (pause_en_i) begin
         act = CG_PAUSE;
      end else if (bp_en_i) begin
         act = CG_BACKP;
      end else begin
         act = CG_DROP;
      end
   end

   assign pause_o = act == CG_PAUSE;
   assign bp_o    = act == CG_BACKP;
   assign drop_o  = act == CG_DROP;

endmodule

// File: rtl/page_pool_mgr.sv
module page_pool_mgr #(
   parameter int NUM_PORTS = 4,
   parameter int PAGE_BITS = 9,
   parameter int NUM_PAGES = 512,
   parameter bit RR_ARB    = 1'b1,
   localparam int CNT_W    = ppm_pkg::cnt_width(NUM_PAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] alloc_req_i,
   input  logic                 rel_vld_i,
   input  logic [PAGE_BITS-1:0] rel_page_i,
   input  logic [CNT_W-1:0]     thresh_i,
   input  logic                 pause_en_i,
   input  logic                 bp_en_i,
   output logic [NUM_PORTS-1:0] gnt_o,
   output logic [PAGE_BITS-1:0] gnt_page_o,
   output logic [CNT_W-1:0]     free_cnt_o,
   output logic                 full_o,
   output logic                 pause_o,
   output logic                 bp_o,
   output logic                 drop_o,
   output logic                 rel_err_o
);

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > (1 << PAGE_BITS)) begin : g_bad_pages
         $error("NUM_PAGES must be 2..2**PAGE_BITS");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("NUM_PORTS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]     cnt;
   logic [PAGE_BITS-1:0] head;
   logic                 alloc_ok;
   logic                 rel_bad;
   logic                 rel_take;
   logic                 rel_err_q;

   assign alloc_ok = cnt != '0;
   assign rel_bad  = rel_vld_i && (cnt == CNT_W'(NUM_PAGES));
   assign rel_take = rel_vld_i && !rel_bad;

   ppm_rr_arb #(
      .NUM_PORTS (NUM_PORTS),
      .RR_ARB    (RR_ARB)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (alloc_ok),
      .req_i (alloc_req_i),
      .gnt_o (gnt_o)
   );

   ppm_ptr_store #(
      .NUM_PAGES (NUM_PAGES),
      .PAGE_BITS (PAGE_BITS)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .pop_i       (gnt_o != '0),
      .push_i      (rel_take),
      .push_page_i (rel_page_i),
      .head_o      (head),
      .count_o     (cnt)
   );

   ppm_congest #(
      .CNT_W (CNT_W)
   ) u_cong (
      .free_cnt_i (cnt),
      .thresh_i   (thresh_i),
      .pause_en_i (pause_en_i),
      .bp_en_i    (bp_en_i),
      .full_o     (full_o),
      .pause_o    (pause_o),
      .bp_o       (bp_o),
      .drop_o     (drop_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_err_q <= 1'b0;
      end else begin
         rel_err_q <= rel_bad;
      end
   end

   assign gnt_page_o = (gnt_o != '0) ? head : '0;
   assign free_cnt_o = cnt;
   assign rel_err_o  = rel_err_q;

   AST_REL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vld_i && free_cnt_o == CNT_W'(NUM_PAGES)) |=> rel_err_o); // R8
   AST_REL_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vld_i && free_cnt_o == CNT_W'(NUM_PAGES) && gnt_o == '0)
         |=> free_cnt_o == CNT_W'(NUM_PAGES)); // R8
   AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pause_o, bp_o, drop_o})); // R10
   AST_ACT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      full_o == (pause_o || bp_o || drop_o)); // R10
   AST_CNT_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && !rel_vld_i) |=> free_cnt_o == $past(free_cnt_o) - 1'b1); // R6

endmodule

// File: tb/page_pool_mgr_tb_top.sv
`timescale 1ns/1ps
module page_pool_mgr_tb_top;

   localparam int NP    = 4;
   localparam int PB    = 9;
   localparam int PAGES = 512;
   localparam int CW    = 10;

   // [15:6] thresh, [5] pause_en, [4] bp_en, [3] full, [2] pause, [1] bp, [0] drop
   localparam logic [15:0] VEC [8] = '{
      {10'd0,   2'b00, 4'b0000},
      {10'd511, 2'b11, 4'b0000},
      {10'd512, 2'b00, 4'b1001},
      {10'd512, 2'b10, 4'b1100},
      {10'd512, 2'b01, 4'b1010},
      {10'd512, 2'b11, 4'b1100},
      {10'd600, 2'b01, 4'b1010},
      {10'd0,   2'b11, 4'b0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] alloc_req = '0;
   logic          rel_vld = 1'b0;
   logic [PB-1:0] rel_page = '0;
   logic [CW-1:0] thresh = '0;
   logic          pause_en = 1'b0;
   logic          bp_en = 1'b0;
   logic [NP-1:0] gnt;
   logic [PB-1:0] gnt_page;
   logic [CW-1:0] free_cnt;
   logic          full, pause, bp, drop, rel_err;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   page_pool_mgr #(
      .NUM_PORTS (NP),
      .PAGE_BITS (PB),
      .NUM_PAGES (PAGES)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_req_i (alloc_req),
      .rel_vld_i   (rel_vld),
      .rel_page_i  (rel_page),
      .thresh_i    (thresh),
      .pause_en_i  (pause_en),
      .bp_en_i     (bp_en),
      .gnt_o       (gnt),
      .gnt_page_o  (gnt_page),
      .free_cnt_o  (free_cnt),
      .full_o      (full),
      .pause_o     (pause),
      .bp_o        (bp),
      .drop_o      (drop),
      .rel_err_o   (rel_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [NP-1:0] r, input logic rv, input logic [PB-1:0] rp);
      @(negedge clk);
      alloc_req = r;
      rel_vld   = rv;
      rel_page  = rp;
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 count", int'(free_cnt), PAGES);
      check("R1 gnt", int'(gnt), 0);
      check("R1 rel_err", int'(rel_err), 0);
      check("R9 full at reset", int'(full), 0);

      // R9 / R10: table walk at free count 512
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         thresh   = VEC[v][15:6];
         pause_en = VEC[v][5];
         bp_en    = VEC[v][4];
         #1;
         check("R9 full", int'(full), int'(VEC[v][3]));
         check("R10 action", int'({pause, bp, drop}), int'(VEC[v][2:0]));
      end
      @(negedge clk);
      thresh = '0; pause_en = 1'b0; bp_en = 1'b0;

      // R2: ascending order from port 0
      for (int i = 0; i < 3; i++) begin
         drive(4'b0001, 1'b0, '0);
         check("R2 gnt", int'(gnt), 1);
         check("R2 page", int'(gnt_page), i);
      end
      // R4: all request, rotation 1,2,3,0
      drive(4'b1111, 1'b0, '0);
      check("R4 gnt p1", int'(gnt), 2);  check("R2 page", int'(gnt_page), 3);
      drive(4'b1111, 1'b0, '0);
      check("R4 gnt p2", int'(gnt), 4);  check("R2 page", int'(gnt_page), 4);
      drive(4'b1111, 1'b0, '0);
      check("R4 gnt p3", int'(gnt), 8);  check("R2 page", int'(gnt_page), 5);
      drive(4'b1111, 1'b0, '0);
      check("R4 gnt p0", int'(gnt), 1);  check("R2 page", int'(gnt_page), 6);
      drive(4'b0101, 1'b0, '0);
      check("R4 gnt p2 skip", int'(gnt), 4); check("R3 page", int'(gnt_page), 7);
      drive(4'b0101, 1'b0, '0);
      check("R4 gnt wrap p0", int'(gnt), 1); check("R3 page", int'(gnt_page), 8);
      check("R6 count before", int'(free_cnt), 504);

      // R6: grant and release together
      drive(4'b0010, 1'b1, 9'd4);
      check("R3 gnt p1", int'(gnt), 2);
      check("R2 page", int'(gnt_page), 9);
      check("R6 count pre", int'(free_cnt), 503);
      drive(4'b0000, 1'b1, 9'd2);
      check("R6 hold", int'(free_cnt), 503);
      drive(4'b0000, 1'b0, '0);
      check("R6 release inc", int'(free_cnt), 504);

      // R2/R7: drain fresh pages then reuse returned ones
      for (int i = 0; i < 502; i++) begin
         drive(4'b1000, 1'b0, '0);
         check("R2 drain page", int'(gnt_page), 10 + i);
      end
      drive(4'b1000, 1'b0, '0);
      check("R7 first returned", int'(gnt_page), 4);
      drive(4'b1000, 1'b0, '0);
      check("R7 second returned", int'(gnt_page), 2);

      // R5 / R9 / R10 at empty pool
      drive(4'b1111, 1'b0, '0);
      check("R5 count", int'(free_cnt), 0);
      check("R5 no gnt", int'(gnt), 0);
      check("R9 full empty", int'(full), 1);
      check("R10 drop", int'({pause, bp, drop}), 1);
      pause_en = 1'b1;
      #1;
      check("R10 pause", int'({pause, bp, drop}), 4);
      pause_en = 1'b0;

      drive(4'b0100, 1'b1, 9'd5);
      check("R5 no gnt with release", int'(gnt), 0);
      drive(4'b0100, 1'b0, '0);
      check("R6 count one", int'(free_cnt), 1);
      check("R7 page 5", int'(gnt_page), 5);
      check("R4 gnt p2", int'(gnt), 4);
      drive(4'b0000, 1'b0, '0);
      check("R6 count zero", int'(free_cnt), 0);

      // R8: release into a complete pool
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 count after reset", int'(free_cnt), PAGES);
      drive(4'b0000, 1'b1, 9'd3);
      drive(4'b0000, 1'b0, '0);
      check("R8 rel_err pulse", int'(rel_err), 1);
      check("R8 count", int'(free_cnt), PAGES);
      drive(4'b0001, 1'b0, '0);
      check("R8 rel_err clear", int'(rel_err), 0);
      check("R8 page not stored", int'(gnt_page), 0);
      drive(4'b0000, 1'b0, '0);

      finish_run();
   end

endmodule